// File: doc/BRIEF.md
# Conversion Result Byte Serializer

This block sits between a result store filled by an analog-to-digital converter and the byte-level slave front end of a two-wire serial bus. The converter pushes 12-bit results in the order it produces them. The bus front end asks for one byte at a time. It then reports whether the master acknowledged that byte. The block answers each request with the next byte of the current result.

Every result goes out as two bytes. The first byte holds four padding bits forced to one, followed by the top four result bits. The second byte holds the low eight bits. Results can only be read in the order in which they were stored; the block offers no addressed access.

A not-acknowledge returns the read position to the first stored result. A STOP or repeated START ends the read session, rewinds the read position and discards the stored results. Once every stored result has been sent, further requests return all-ones bytes.

Top module: `result_byte_serializer`

## Requirements
- R1: After reset no results are stored, `tx_byte` reads 0xFF, and a byte request returns 0xFF.
- R2: For a stored result D, the first byte sent is {4'b1111, D[11:8]} and the second byte sent is D[7:0].
- R3: Results are sent in the order in which they were written; the earliest write is sent first.
- R4: `tx_byte` takes the answer to a request on the clock edge that samples `byte_req` high. It keeps that value until the next request.
- R5: An acknowledge of a first byte moves to the second byte of the same result. An acknowledge of a second byte moves to the next result. A request that follows no acknowledge repeats the byte that was last offered.
- R6: A not-acknowledge returns the read position to the first byte of the first stored result, and the stored results are kept.
- R7: `bus_end` rewinds the read position and discards all stored results. A write in the same cycle as `bus_end` becomes the first result of the new set.
- R8: When every stored result has been sent, each request returns 0xFF, and further acknowledges have no effect.
- R9: Writes that arrive while DEPTH results are already stored are dropped. The stored results are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_wr | input | 1 | Write strobe for one conversion result |
| res_data | input | 12 | Conversion result to store |
| bus_end | input | 1 | Pulse on STOP or repeated START |
| byte_req | input | 1 | Front end requests the next byte to send |
| ack_strobe | input | 1 | Master's acknowledge bit for the last byte is valid |
| ack_is_nack | input | 1 | Qualifies `ack_strobe`: 1 means not-acknowledge |
| tx_byte | output | 8 | Byte offered to the bus front end |

## Verification
The assertions assume the following about the front end:
- `byte_req`, `ack_strobe` and `bus_end` are single-cycle pulses.
- A request never coincides with an acknowledge or with `bus_end`.
- `ack_is_nack` matters only while `ack_strobe` is high.

The stimulus drives every pulse for one cycle from tasks that run one after another, so these cases never overlap. The one deliberate overlap is a write in the same cycle as `bus_end`, which R7 defines. Random sessions mix the following at random points:
- different counts of writes, including overflow;
- partial reads;
- repeated requests with no acknowledge in between;
- not-acknowledges.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
   // width of the padding field placed in front of the upper result bits
   function automatic int pad_width(input int data_w, input int byte_w);
      return 2 * byte_w - data_w;
   endfunction
endpackage

// File: rtl/rsz_store.sv
module rsz_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 12,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic [CNT_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  cnt
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              room;
   logic [CNT_W-1:0]  wr_slot;

   assign room    = clr || (cnt < CNT_W'(DEPTH));
   assign wr_slot = clr ? '0 : cnt;

   // contents are left unset at power-up on purpose
   always_ff @(posedge clk) begin
      if (wr_en && room) begin
         mem[wr_slot[IDX_W-1:0]] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= wr_en ? CNT_W'(1) : '0;
      end else if (wr_en && room) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign rd_data = mem[rd_idx[IDX_W-1:0]];
endmodule

// File: rtl/rsz_cursor.sv
module rsz_cursor #(
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   input  logic             nack,
   input  logic             clr,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] ptr,
   output logic             phase,
   output logic             avail
);
   assign avail = ptr < cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         phase <= 1'b0;
      end else if (clr || (ack && nack)) begin
         ptr   <= '0;
         phase <= 1'b0;
      end else if (ack && avail) begin
         if (phase) begin
            ptr   <= ptr + CNT_W'(1);
            phase <= 1'b0;
         end else begin
            phase <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rsz_format.sv
module rsz_format #(
   parameter int DATA_W = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              phase,
   input  logic              avail,
   input  logic [DATA_W-1:0] word,
   output logic [BYTE_W-1:0] tx_byte
);
   import rsz_pkg::*;
   localparam int PAD_W = pad_width(DATA_W, BYTE_W);
   localparam int HI_W  = DATA_W - BYTE_W;

   logic [BYTE_W-1:0] hi_byte;
   logic [BYTE_W-1:0] nxt_byte;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign hi_byte = word[DATA_W-1:BYTE_W];
      end else begin : g_pad
         assign hi_byte = {{PAD_W{1'b1}}, word[DATA_W-1 -: HI_W]};
      end
   endgenerate

   always_comb begin
      if (!avail) begin
         nxt_byte = '1;
      end else if (phase) begin
         nxt_byte = word[BYTE_W-1:0];
      end else begin
         nxt_byte = hi_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_byte <= '1;
      end else if (req) begin
         tx_byte <= nxt_byte;
      end
   end
endmodule

// File: rtl/result_byte_serializer.sv
module result_byte_serializer #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 12,
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_wr,
   input  logic [DATA_W-1:0] res_data,
   input  logic              bus_end,
   input  logic              byte_req,
   input  logic              ack_strobe,
   input  logic              ack_is_nack,
   output logic [BYTE_W-1:0] tx_byte
);
   initial begin
      if (DEPTH < 2) $error("DEPTH must be at least 2");
      if (DATA_W <= BYTE_W || DATA_W > 2 * BYTE_W)
         $error("DATA_W must lie in (BYTE_W, 2*BYTE_W]");
   end

   logic [CNT_W-1:0]  stored_cnt;
   logic [CNT_W-1:0]  rd_ptr;
   logic              rd_phase;
   logic              rd_avail;
   logic [DATA_W-1:0] rd_word;

   rsz_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(res_wr), .wr_data(res_data),
      .clr(bus_end), .rd_idx(rd_ptr), .rd_data(rd_word), .cnt(stored_cnt)
   );

   rsz_cursor #(.DEPTH(DEPTH)) u_cursor (
      .clk(clk), .rst_n(rst_n), .ack(ack_strobe), .nack(ack_is_nack),
      .clr(bus_end), .cnt(stored_cnt), .ptr(rd_ptr), .phase(rd_phase),
      .avail(rd_avail)
   );

   rsz_format #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_format (
      .clk(clk), .rst_n(rst_n), .req(byte_req), .phase(rd_phase),
      .avail(rd_avail), .word(rd_word), .tx_byte(tx_byte)
   );
endmodule

// File: rtl/result_byte_serializer_chk.sv
module result_byte_serializer_chk #(
   parameter int DEPTH  = 16,
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_wr,
   input logic              bus_end,
   input logic              byte_req,
   input logic              ack_strobe,
   input logic              ack_is_nack,
   input logic [BYTE_W-1:0] tx_byte,
   input logic [CNT_W-1:0]  stored_cnt,
   input logic [CNT_W-1:0]  rd_ptr,
   input logic              rd_phase
);
   // R4
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_req |=> $stable(tx_byte));

   // R2
   pad_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_req && !rd_phase && (rd_ptr < stored_cnt) |=> tx_byte[BYTE_W-1 -: 4] == 4'hF);

   // R5
   ptr_moves_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_strobe && !bus_end |=> $stable(rd_ptr) && $stable(rd_phase));

   // R6
   nack_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_strobe && ack_is_nack && !bus_end |=> rd_ptr == '0 && !rd_phase);

   // R7
   end_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_end && !res_wr |=> stored_cnt == '0 && rd_ptr == '0);

   // R8
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr <= stored_cnt);

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stored_cnt <= CNT_W'(DEPTH));
endmodule

bind result_byte_serializer result_byte_serializer_chk #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .bus_end(bus_end),
   .byte_req(byte_req), .ack_strobe(ack_strobe), .ack_is_nack(ack_is_nack),
   .tx_byte(tx_byte), .stored_cnt(stored_cnt), .rd_ptr(rd_ptr),
   .rd_phase(rd_phase)
);

// File: tb/result_byte_serializer_tb.sv
module result_byte_serializer_tb;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_wr = 1'b0;
   logic [11:0] res_data = '0;
   logic        bus_end = 1'b0;
   logic        byte_req = 1'b0;
   logic        ack_strobe = 1'b0;
   logic        ack_is_nack = 1'b0;
   logic [7:0]  tx_byte;

   int tests = 0;
   int fails = 0;

   // reference model
   logic [11:0] m_mem [DEPTH];
   int m_cnt = 0;
   int m_ptr = 0;
   int m_ph  = 0;

   always #4 clk = ~clk;

   result_byte_serializer #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_data(res_data),
      .bus_end(bus_end), .byte_req(byte_req), .ack_strobe(ack_strobe),
      .ack_is_nack(ack_is_nack), .tx_byte(tx_byte)
   );

   function automatic logic [7:0] exp_byte();
      if (m_ptr >= m_cnt) return 8'hFF;
      if (m_ph == 1) return m_mem[m_ptr][7:0];
      return {4'hF, m_mem[m_ptr][11:8]};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: tx_byte=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic write_res(input logic [11:0] d);
      res_wr = 1'b1; res_data = d;
      @(negedge clk);
      res_wr = 1'b0;
      if (m_cnt < DEPTH) begin m_mem[m_cnt] = d; m_cnt++; end
   endtask

   task automatic request(input string tag);
      logic [7:0] e;
      e = exp_byte();
      byte_req = 1'b1;
      @(negedge clk);
      byte_req = 1'b0;
      check(tag, tx_byte, e);
   endtask

   task automatic acknowledge(input bit nack);
      ack_strobe = 1'b1; ack_is_nack = nack;
      @(negedge clk);
      ack_strobe = 1'b0; ack_is_nack = 1'b0;
      if (nack) begin m_ptr = 0; m_ph = 0; end
      else if (m_ptr < m_cnt) begin
         if (m_ph == 1) begin m_ptr++; m_ph = 0; end else m_ph = 1;
      end
   endtask

   task automatic end_session(input bit with_wr, input logic [11:0] d);
      bus_end = 1'b1; res_wr = with_wr; res_data = d;
      @(negedge clk);
      bus_end = 1'b0; res_wr = 1'b0;
      m_ptr = 0; m_ph = 0; m_cnt = 0;
      if (with_wr) begin m_mem[0] = d; m_cnt = 1; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and empty store
      check("R1", tx_byte, 8'hFF);
      request("R1");

      // R2 / R3: frame layout and order
      write_res(12'hA5C);
      write_res(12'h3E1);
      write_res(12'h007);
      request("R2");
      check("R2", tx_byte, 8'hFA);
      // R4: held without request
      repeat (3) @(negedge clk);
      check("R4", tx_byte, 8'hFA);
      // R5: repeat without ack
      request("R5");
      acknowledge(0);
      request("R2");
      check("R2", tx_byte, 8'h5C);
      acknowledge(0);
      request("R3");
      check("R3", tx_byte, 8'hF3);
      acknowledge(0);
      request("R3");
      acknowledge(0);
      // R6: nack rewinds, results kept
      acknowledge(1);
      request("R6");
      check("R6", tx_byte, 8'hFA);
      // R8: read to exhaustion
      for (int i = 0; i < 6; i++) begin acknowledge(0); request("R8"); end
      check("R8", tx_byte, 8'hFF);
      acknowledge(0);
      request("R8");
      // R7: bus end discards, concurrent write kept
      end_session(0, '0);
      request("R7");
      check("R7", tx_byte, 8'hFF);
      end_session(1, 12'hBCD);
      request("R7");
      check("R7", tx_byte, 8'hFB);
      // R9: overflow writes dropped
      end_session(0, '0);
      for (int i = 0; i < DEPTH + 3; i++) write_res(12'(i * 37 + 5));
      for (int i = 0; i < 2 * DEPTH; i++) begin request("R9"); acknowledge(0); end
      request("R9");
      check("R9", tx_byte, 8'hFF);

      // random sessions
      for (int s = 0; s < 60; s++) begin
         end_session($urandom_range(0, 3) == 0, 12'($urandom));
         for (int w = $urandom_range(0, DEPTH + 2); w > 0; w--) write_res(12'($urandom));
         for (int b = $urandom_range(1, 40); b > 0; b--) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 6) begin request("R3"); acknowledge(0); end
            else if (op < 8) request("R5");
            else if (op < 9) acknowledge(1);
            else write_res(12'($urandom));
         end
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule